// File: doc/BRIEF.md
# Rank Interleave Range Decoder

This block turns an address that is already local to one memory channel into the coordinates of a rank: which DIMM on the channel, which rank on that DIMM, and the address within that rank. Software programs four range entries. Each entry has a range word that holds a valid bit, an upper limit and a way count. Each entry also has up to eight interleave words, one for each way, and each interleave word holds a channel-rank number and an offset.

A lookup first finds the entry whose address window contains the request. The interleave granularity is set by the page policy of the channel. The way index taken from the address bits above the granularity picks one of the entry's interleave words. The way bits are then squeezed out of the address, with the bits below the granularity kept as they are, and the selected offset is subtracted from the result.

Requests arrive on a valid/ready input and are not accepted while a configuration write is under way. Each accepted request yields one registered result one cycle later. A request that falls in no valid window returns a miss flag.

Top module: `rank_ilv_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` and `out_miss` are 0, and `out_dimm`, `out_rank` and `out_rank_addr` are 0.
- R2: `in_ready` is low in any cycle where `cfg_we` is high, and high otherwise.
- R3: A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. `out_valid` is high for exactly the cycle after each accepted request and low after any other cycle.
- R4: In a range word, bit 31 is the valid bit, bits [11:1] form the limit field, and bits [29:28] form the way-count field. The entry's upper limit is the limit field shifted left by 29 with the low 29 bits all set to one.
- R5: Entries are scanned from index 0 upward. The lower bound of entry 0's window is 0, and each later entry's lower bound is the previous entry's upper limit plus one, whether or not that previous entry is valid. The first valid entry with lower bound ≤ address ≤ upper limit is the hit.
- R6: If no valid entry contains the address, `out_miss` is 1 and `out_dimm`, `out_rank` and `out_rank_addr` are all 0.
- R7: The way count is 1 shifted left by the way-count field, which gives 1, 2, 4 or 8 ways.
- R8: The granularity shift is 6 when `in_close_pg` is 1 and 13 when it is 0.
- R9: Before the offset is applied, the rank address is ((addr >> shift) / ways) << shift, with the low `shift` bits of addr ORed back in.
- R10: The way index is (addr >> shift) mod ways, and it selects the hit entry's interleave word for that way. The word's bits [15:2], shifted left by 26, are subtracted from the rank address modulo 2^CA_W. Bits [19:16] of the word are the channel rank: `out_dimm` is the channel rank / 4 and `out_rank` is the channel rank mod 4.
- R11: When `cfg_we` is high, `cfg_is_ilv`=0 writes `cfg_wdata` to the range word of entry `cfg_range`, and `cfg_is_ilv`=1 writes it to the interleave word for way `cfg_way` of entry `cfg_range`. Reset clears every range word, so every lookup misses until an entry is programmed. Interleave words are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_ilv | input | 1 | 0: write a range word, 1: write an interleave word |
| cfg_range | input | RIDX_W | Entry index of the write |
| cfg_way | input | 3 | Way index of an interleave-word write |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request may be accepted |
| in_addr | input | CA_W | Channel-local address |
| in_close_pg | input | 1 | Channel uses the closed-page policy |
| out_valid | output | 1 | Result valid (one-cycle pulse) |
| out_miss | output | 1 | No valid entry contained the address |
| out_dimm | output | 2 | DIMM number |
| out_rank | output | 2 | Rank within the DIMM |
| out_rank_addr | output | CA_W | Rank-local address |

## Verification
The bench probes the window edges: the last address of an entry and the first address past an invalid entry. A design that did not advance the lower bound over an invalid entry would return a hit where a miss is due. The bench compares closed-page and open-page lookups at the same address to catch a swapped granularity. It runs an eight-way lookup at the top way index to catch a mask that is one bit too narrow. It makes the offset larger than the rank address to expose a design that saturates the subtraction or truncates it to the wrong width. Random reprogramming, with limits that are not in order, checks that the lowest index wins when windows overlap, and checks that requests sent during configuration writes are ignored.

// File: rtl/rkdec_pkg.sv
`timescale 1ns/1ps
package rkdec_pkg;
  localparam int WORD_W       = 32;
  // range word fields
  localparam int RW_VALID     = 31;
  localparam int RW_LIM_LO    = 1;
  localparam int RW_LIM_W     = 11;
  localparam int RW_WAYS_LO   = 28;
  localparam int WAYS_LOG_W   = 2;
  // interleave word fields
  localparam int IW_OFF_LO    = 2;
  localparam int IW_OFF_W     = 14;
  localparam int IW_CR_LO     = 16;
  // scaling
  localparam int LIMIT_SHIFT  = 29;
  localparam int OFFSET_SHIFT = 26;
  localparam int GRAN_CLOSED  = 6;
  localparam int GRAN_OPEN    = 13;
  localparam int MAX_WAYS     = 1 << ((1 << WAYS_LOG_W) - 1);
  localparam int WAY_W        = $clog2(MAX_WAYS);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rkdec_cfg_store.sv
`timescale 1ns/1ps
module rkdec_cfg_store
  import rkdec_pkg::*;
#(
  parameter int NRANGE = 4,
  localparam int RIDX_W = $clog2(NRANGE)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic                     is_ilv,
  input  logic [RIDX_W-1:0]        wr_range,
  input  logic [WAY_W-1:0]         wr_way,
  input  word_t                    wdata,
  output word_t [NRANGE-1:0]       range_words,
  input  logic [RIDX_W-1:0]        rd_range,
  input  logic [WAY_W-1:0]         rd_way,
  output word_t                    ilv_word
);
  localparam int DEPTH = (1 << RIDX_W) * MAX_WAYS;

  // interleave words: plain memory, no reset, distributed-RAM friendly
  word_t ilv_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && is_ilv) ilv_mem[{wr_range, wr_way}] <= wdata;
  end

  assign ilv_word = ilv_mem[{rd_range, rd_way}];

  // range words: reset so every entry starts invalid
  always_ff @(posedge clk) begin
    if (rst) begin
      range_words <= '0;
    end else if (we && !is_ilv) begin
      range_words[wr_range] <= wdata;
    end
  end
endmodule

// File: rtl/rkdec_range_match.sv
`timescale 1ns/1ps
module rkdec_range_match
  import rkdec_pkg::*;
#(
  parameter int NRANGE = 4,
  parameter int CA_W   = 40,
  localparam int RIDX_W = $clog2(NRANGE)
) (
  input  word_t [NRANGE-1:0]  range_words,
  input  logic [CA_W-1:0]     addr,
  output logic                hit,
  output logic [RIDX_W-1:0]   hit_idx
);
  logic [CA_W:0]     lower [NRANGE+1];
  logic [CA_W-1:0]   upper [NRANGE];
  logic [NRANGE-1:0] in_win;

  assign lower[0] = '0;

  for (genvar g = 0; g < NRANGE; g++) begin : g_ent
    assign upper[g]   = CA_W'({range_words[g][RW_LIM_LO +: RW_LIM_W], {LIMIT_SHIFT{1'b1}}});
    // bound advances whether the entry is valid or not
    assign lower[g+1] = {1'b0, upper[g]} + (CA_W+1)'(1);
    assign in_win[g]  = range_words[g][RW_VALID]
                        && ({1'b0, addr} >= lower[g])
                        && (addr <= upper[g]);
  end

  // lowest index wins
  always_comb begin
    hit     = |in_win;
    hit_idx = '0;
    for (int i = NRANGE - 1; i >= 0; i--) begin
      if (in_win[i]) hit_idx = RIDX_W'(i);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{range_words, lower[NRANGE]};
endmodule

// File: rtl/rkdec_addr_xform.sv
`timescale 1ns/1ps
module rkdec_addr_xform
  import rkdec_pkg::*;
#(
  parameter int CA_W = 40
) (
  input  logic [CA_W-1:0]       addr,
  input  logic                  close_pg,
  input  logic [WAYS_LOG_W-1:0] ways_log,
  input  word_t                 ilv_word,
  output logic [WAY_W-1:0]      way_idx,
  output logic [CA_W-1:0]       rank_addr,
  output logic [1:0]            dimm,
  output logic [1:0]            rank
);
  logic [3:0]      gran;
  logic [CA_W-1:0] shifted, quot, lowmask, rebuilt, offset;

  always_comb begin
    gran      = close_pg ? 4'(GRAN_CLOSED) : 4'(GRAN_OPEN);
    shifted   = addr >> gran;
    way_idx   = shifted[WAY_W-1:0] & WAY_W'((1 << ways_log) - 1);
    quot      = shifted >> ways_log;
    lowmask   = (CA_W'(1) << gran) - CA_W'(1);
    rebuilt   = (quot << gran) | (addr & lowmask);
    offset    = CA_W'(ilv_word[IW_OFF_LO +: IW_OFF_W]) << OFFSET_SHIFT;
    rank_addr = rebuilt - offset;
    dimm      = ilv_word[IW_CR_LO+2 +: 2];
    rank      = ilv_word[IW_CR_LO +: 2];
  end

  logic unused_bits;
  assign unused_bits = ^{ilv_word[WORD_W-1:IW_CR_LO+4], ilv_word[IW_OFF_LO-1:0]};
endmodule

// File: rtl/rank_ilv_decoder.sv
`timescale 1ns/1ps
module rank_ilv_decoder
  import rkdec_pkg::*;
#(
  parameter int NRANGE = 4,
  parameter int CA_W   = 40,
  localparam int RIDX_W = $clog2(NRANGE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_is_ilv,
  input  logic [RIDX_W-1:0]   cfg_range,
  input  logic [2:0]          cfg_way,
  input  logic [31:0]         cfg_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CA_W-1:0]     in_addr,
  input  logic                in_close_pg,
  output logic                out_valid,
  output logic                out_miss,
  output logic [1:0]          out_dimm,
  output logic [1:0]          out_rank,
  output logic [CA_W-1:0]     out_rank_addr
);
  word_t [NRANGE-1:0]    range_words;
  word_t                 ilv_word;
  logic                  hit;
  logic [RIDX_W-1:0]     hit_idx;
  logic [WAY_W-1:0]      way_idx;
  logic [WAYS_LOG_W-1:0] ways_log;
  logic [CA_W-1:0]       rank_addr;
  logic [1:0]            dimm, rank;
  logic                  accept;

  assign in_ready = !cfg_we;
  assign accept   = in_valid && in_ready;

  rkdec_cfg_store #(.NRANGE(NRANGE)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .is_ilv(cfg_is_ilv),
    .wr_range(cfg_range), .wr_way(cfg_way), .wdata(cfg_wdata),
    .range_words(range_words), .rd_range(hit_idx), .rd_way(way_idx),
    .ilv_word(ilv_word)
  );

  rkdec_range_match #(.NRANGE(NRANGE), .CA_W(CA_W)) u_match (
    .range_words(range_words), .addr(in_addr), .hit(hit), .hit_idx(hit_idx)
  );

  assign ways_log = range_words[hit_idx][RW_WAYS_LO +: WAYS_LOG_W];

  rkdec_addr_xform #(.CA_W(CA_W)) u_xform (
    .addr(in_addr), .close_pg(in_close_pg), .ways_log(ways_log),
    .ilv_word(ilv_word), .way_idx(way_idx), .rank_addr(rank_addr),
    .dimm(dimm), .rank(rank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_miss      <= 1'b0;
      out_dimm      <= '0;
      out_rank      <= '0;
      out_rank_addr <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_miss      <= !hit;
        out_dimm      <= hit ? dimm : 2'b00;
        out_rank      <= hit ? rank : 2'b00;
        out_rank_addr <= hit ? rank_addr : '0;
      end
    end
  end
endmodule

// File: rtl/rkdec_checker.sv
`timescale 1ns/1ps
module rkdec_checker #(
  parameter int CA_W = 40
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic            in_valid,
  input logic            in_ready,
  input logic [CA_W-1:0] in_addr,
  input logic            in_close_pg,
  input logic            out_valid,
  input logic            out_miss,
  input logic [1:0]      out_dimm,
  input logic [1:0]      out_rank,
  input logic [CA_W-1:0] out_rank_addr
);
  p_busy_r2: assert property (@(posedge clk) disable iff (rst) cfg_we |-> !in_ready);
  p_open_r2: assert property (@(posedge clk) disable iff (rst) !cfg_we |-> in_ready);
  p_resp_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_dimm == 2'b00 && out_rank == 2'b00 && out_rank_addr == '0));
  p_low_closed_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_close_pg) |=>
      (out_miss || out_rank_addr[5:0] == $past(in_addr[5:0])));
  p_low_open_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_close_pg) |=>
      (out_miss || out_rank_addr[12:0] == $past(in_addr[12:0])));
endmodule

bind rank_ilv_decoder rkdec_checker #(.CA_W(CA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .in_valid(in_valid),
  .in_ready(in_ready), .in_addr(in_addr), .in_close_pg(in_close_pg),
  .out_valid(out_valid), .out_miss(out_miss), .out_dimm(out_dimm),
  .out_rank(out_rank), .out_rank_addr(out_rank_addr)
);

// File: tb/rank_ilv_decoder_tb_top.sv
`timescale 1ns/1ps
module rank_ilv_decoder_tb_top;
  localparam int CA_W = 40;
  localparam longint AMASK = (64'd1 << CA_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, cfg_we = 1'b0, cfg_is_ilv = 1'b0;
  logic [1:0] cfg_range = '0;
  logic [2:0] cfg_way = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_close_pg = 1'b0;
  logic [CA_W-1:0] in_addr = '0;
  logic in_ready, out_valid, out_miss;
  logic [1:0] out_dimm, out_rank;
  logic [CA_W-1:0] out_rank_addr;

  rank_ilv_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_ilv(cfg_is_ilv),
    .cfg_range(cfg_range), .cfg_way(cfg_way), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_close_pg(in_close_pg), .out_valid(out_valid), .out_miss(out_miss),
    .out_dimm(out_dimm), .out_rank(out_rank), .out_rank_addr(out_rank_addr)
  );

  int total = 0, bad = 0;

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_rw [4];
  logic [31:0] m_iw [4][8];
  bit     exp_valid = 0, exp_miss = 0;
  int     exp_dimm = 0, exp_rank = 0;
  longint exp_ra = 0;

  function automatic void model(input longint a, input bit cp, output bit miss,
                                output int dimm, output int rank, output longint ra);
    longint prev = 0, lim, q, r, off;
    int hit = -1, s, w, idx, cr;
    logic [31:0] iw;
    for (int i = 0; i < 4; i++) begin
      lim = ((longint'(m_rw[i]) >> 1) & 'h7ff) * (64'd1 << 29) + 'h1fffffff;
      if (m_rw[i][31] && hit < 0 && a >= prev && a <= lim) hit = i;
      prev = lim + 1;
    end
    miss = (hit < 0); dimm = 0; rank = 0; ra = 0;
    if (hit >= 0) begin
      s   = cp ? 6 : 13;
      w   = 1 << ((m_rw[hit] >> 28) & 3);
      q   = a / (64'd1 << s);
      idx = int'(q % w);
      r   = (q / w) * (64'd1 << s) + (a % (64'd1 << s));
      iw  = m_iw[hit][idx];
      off = ((longint'(iw) >> 2) & 'h3fff) * (64'd1 << 26);
      ra  = (r - off) & AMASK;
      cr  = (iw >> 16) & 15;
      dimm = cr / 4;
      rank = cr % 4;
    end
  endfunction

  always @(posedge clk) begin : mdl
    bit mm; int dd, rr; longint aa;
    if (rst) begin
      exp_valid <= 0; exp_miss <= 0; exp_dimm <= 0; exp_rank <= 0; exp_ra <= 0;
      for (int i = 0; i < 4; i++) m_rw[i] <= '0;
    end else begin
      exp_valid <= in_valid && !cfg_we;
      if (in_valid && !cfg_we) begin
        model(longint'(in_addr), in_close_pg, mm, dd, rr, aa);
        exp_miss <= mm; exp_dimm <= dd; exp_rank <= rr; exp_ra <= aa;
      end
      if (cfg_we) begin
        if (cfg_is_ilv) m_iw[cfg_range][cfg_way] <= cfg_wdata;
        else            m_rw[cfg_range] <= cfg_wdata;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 out_valid", out_valid == exp_valid, out_valid, exp_valid);
      if (exp_valid) begin
        check("R5 out_miss", out_miss == exp_miss, out_miss, exp_miss);
        if (exp_miss) begin
          check("R6 zero on miss", out_dimm == 0 && out_rank == 0 && out_rank_addr == 0,
                {out_dimm, out_rank, out_rank_addr}, 0);
        end else begin
          check("R10 dimm", out_dimm == exp_dimm, out_dimm, exp_dimm);
          check("R10 rank", out_rank == exp_rank, out_rank, exp_rank);
          check("R9 rank_addr", longint'(out_rank_addr) == exp_ra, out_rank_addr, exp_ra);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mkrw(input bit v, input int wl, input int lim);
    return {v, 1'b0, 2'(wl), 16'd0, 11'(lim), 1'b0};
  endfunction
  function automatic logic [31:0] mkiw(input int off, input int cr);
    return {12'd0, 4'(cr), 14'(off), 2'b00};
  endfunction

  task automatic cfg_write(input bit ilv, input int rng, input int way, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_is_ilv = ilv; cfg_range = 2'(rng); cfg_way = 3'(way); cfg_wdata = d;
    in_valid = 1; in_addr = '0;                 // must be ignored
    #1 check("R2 ready low during write", in_ready == 0, in_ready, 0);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
  endtask

  task automatic lookup(input longint a, input bit cp, input bit emiss,
                        input int ed, input int er, input longint ea, input string tag);
    @(negedge clk);
    in_valid = 1; in_addr = CA_W'(a); in_close_pg = cp;
    #1 check("R2 ready high", in_ready == 1, in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    check({tag, " miss"}, out_valid && out_miss == emiss, {out_valid, out_miss}, {1'b1, emiss});
    check({tag, " dimm/rank"}, out_dimm == ed && out_rank == er, {out_dimm, out_rank}, {2'(ed), 2'(er)});
    check({tag, " rank_addr"}, longint'(out_rank_addr) == ea, out_rank_addr, ea);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid/miss", out_valid == 0 && out_miss == 0, {out_valid, out_miss}, 0);
    check("R1 reset data", out_dimm == 0 && out_rank == 0 && out_rank_addr == 0,
          {out_dimm, out_rank, out_rank_addr}, 0);
    rst = 0;
    @(negedge clk);
    check("R1 first cycle", out_valid == 0, out_valid, 0);

    lookup(64'h1000, 1, 1, 0, 0, 0, "R11 empty table");

    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 8; w++)
        cfg_write(1, r, w, r == 0 ? mkiw(0, 5) : r == 1 ? mkiw(0, 15) :
                           r == 2 ? mkiw(1, 12 + w) : mkiw(w, w));
    cfg_write(0, 0, 0, mkrw(1, 0, 1));
    cfg_write(0, 1, 0, mkrw(0, 1, 3));
    cfg_write(0, 2, 0, mkrw(1, 2, 7));
    cfg_write(0, 3, 0, mkrw(1, 3, 'h7ff));

    lookup(64'h123456, 1, 0, 1, 1, 64'h123456, "R5 entry0");
    lookup(64'h3FFFFFFF, 0, 0, 1, 1, 64'h3FFFFFFF, "R5 upper inclusive");
    lookup(64'h40000000, 0, 1, 0, 0, 0, "R5 invalid entry skipped R6");
    lookup(64'h80000000, 0, 0, 3, 0, 64'h1C000000, "R7 first after invalid");
    lookup(64'h80002040, 0, 0, 3, 1, 64'h1C000040, "R8 open shift");
    lookup(64'h80002040, 1, 0, 3, 1, 64'h1C000800, "R8 closed shift");
    lookup(64'h1000001C0, 1, 0, 1, 3, 64'h4000000, "R7 eight ways top index R10");
    cfg_write(0, 3, 0, mkrw(0, 3, 'h7ff));
    lookup(64'h1000001C0, 1, 1, 0, 0, 0, "R4 valid bit clear");
    cfg_write(0, 3, 0, mkrw(1, 3, 'h7ff));
    cfg_write(1, 0, 0, mkiw(1, 5));
    lookup(64'h100, 1, 0, 1, 1, 64'hFFFC000100, "R10 offset wraps");

    // random traffic, checked every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; cfg_is_ilv = $urandom_range(0, 1) == 1;
        cfg_range = 2'($urandom); cfg_way = 3'($urandom);
        cfg_wdata = cfg_is_ilv ? mkiw($urandom_range(0, 16383), $urandom_range(0, 15))
                               : mkrw($urandom_range(0, 3) != 0, $urandom_range(0, 3),
                                      $urandom_range(0, 2047));
        in_valid = $urandom_range(0, 1) == 1;
      end else begin
        cfg_we = 0;
        in_valid = $urandom_range(0, 3) != 0;
      end
      in_close_pg = $urandom_range(0, 1) == 1;
      in_addr = CA_W'({$urandom, $urandom});
      if ($urandom_range(0, 1) == 1) in_addr = in_addr & CA_W'(64'hF_FFFF_FFFF);
    end
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule